// File: doc/BRIEF.md
# Constructive Cross-Coupled Gate Evaluator

This block settles one tick of a two-gate feedback loop in which each gate's output inhibits the other. The equations are `res_a = src_a AND NOT res_b` and `res_b = src_b AND NOT res_a`. The loop has no fixed topological order, so the block does not guess a value. It tracks three states per wire (unknown, proven 0, proven 1). It only records a value once that value follows from facts already established. Which wire is proven first therefore depends on the input data.

A `start` strobe does three things. It latches both sources, clears both wires to unknown and loads each gate's pending-input counter with its fan-in. After that, each clock cycle performs exactly one propagation step. In a step, every gate does two things:
- It consumes any input fact that has newly become known, and decrements its counter for each one.
- It writes its output as soon as the facts force a value. A controlling input (source 0, or the other wire at 1) forces 0. Two known non-controlling inputs force 1.

A step that changes nothing ends the tick with a one-cycle `done` pulse. The block counts every consumed input fact during the tick. If that count falls short of the total fan-in, some wire could not be proven, and `nonconstructive` is raised.

Top module: `cn_eval`

## Requirements
- R1: After reset, `done`, `nonconstructive`, `res_a_known` and `res_b_known` are all 0.
- R2: With src_a=0 and src_b=1, `done` rises 4 cycles after the clock edge that accepts `start`. The result is res_a=0 and res_b=1, both with the known flag at 1, and `nonconstructive`=0.
- R3: With src_a=1 and src_b=0, `done` rises 4 cycles after the accepting edge. The result is res_a=1 and res_b=0, both known, and `nonconstructive`=0.
- R4: With src_a=0 and src_b=0, `done` rises 3 cycles after the accepting edge. Both results are 0 and known, and `nonconstructive`=0.
- R5: With src_a=1 and src_b=1, `done` rises 2 cycles after the accepting edge. Both known flags stay 0 and `nonconstructive`=1.
- R6: `done` is high for exactly one cycle. The results, known flags and `nonconstructive` hold their values until the next accepted `start`.
- R7: A `start` that arrives while a tick is being evaluated is ignored, along with the sources presented with it. The result and the latency are those of the tick already in progress.
- R8: Within a tick each wire is written at most once, and a gate never consumes an input fact when its pending counter is already 0.
- R9: `nonconstructive` is 1 exactly when the number of input facts consumed during the tick differs from the total fan-in (2 gates × FANIN). It can only become 1 in the cycle in which `done` is asserted.
- R10: A tick takes at most 2 × total fan-in + 1 propagation steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a tick; sampled only when idle |
| src_a | input | 1 | Source input of gate A |
| src_b | input | 1 | Source input of gate B |
| res_a | output | 1 | Value of wire A (meaningful when res_a_known) |
| res_b | output | 1 | Value of wire B (meaningful when res_b_known) |
| res_a_known | output | 1 | Wire A has been proven |
| res_b_known | output | 1 | Wire B has been proven |
| done | output | 1 | One-cycle pulse: fixpoint reached |
| nonconstructive | output | 1 | Some wire was left unproven in the last tick |

## Verification
The bench builds the block with its default FANIN of 2, which is the only value that matches the two-input gates. With that value the total fan-in is 4. Each of the four source patterns can then be driven to its fixpoint, and its latency can be compared with a count derived by hand from the proof order. That count is four steps when one wire must wait for the other, three when both wires are forced at once, and two when neither can be proven. Because the counters are this small, back-to-back ticks with no reset between them, and a `start` inserted in the middle of a tick, are also within reach.

// File: rtl/cn_pkg.sv
package cn_pkg;
  // a wire fact: known flag plus value
  typedef struct packed {
    logic known;
    logic val;
  } fact_t;

  localparam int N_GATES = 2;
endpackage

// File: rtl/cn_gate.sv
module cn_gate
  import cn_pkg::*;
#(
  parameter int FANIN = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic                         step,
  input  fact_t                        ext_i,
  input  fact_t                        fb_i,
  output fact_t                        out_o,
  output logic [$clog2(FANIN+1)-1:0]   ev_o,
  output logic                         chg_o
);
  localparam int CW = $clog2(FANIN + 1);

  logic          seen_ext, seen_fb;
  logic [CW-1:0] pend_q;
  fact_t         w_q;
  logic          new_ext, new_fb, force0, force1, wr;

  always_comb begin
    new_ext = step && ext_i.known && !seen_ext;
    new_fb  = step && fb_i.known && !seen_fb;
    // controlling value on either input proves 0
    force0  = (ext_i.known && !ext_i.val) || (fb_i.known && fb_i.val);
    // both inputs known and non-controlling proves 1
    force1  = ext_i.known && fb_i.known && ext_i.val && !fb_i.val;
    wr      = step && !w_q.known && (force0 || force1);
    ev_o    = CW'(new_ext) + CW'(new_fb);
    chg_o   = new_ext || new_fb || wr;
    out_o   = w_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen_ext <= 1'b0;
      seen_fb  <= 1'b0;
      pend_q   <= CW'(FANIN);
      w_q      <= '0;
    end else begin
      if (new_ext) seen_ext <= 1'b1;
      if (new_fb)  seen_fb  <= 1'b1;
      pend_q <= pend_q - CW'(new_ext) - CW'(new_fb);
      if (wr) begin
        w_q.known <= 1'b1;
        w_q.val   <= !force0;
      end
    end
  end

  // R8: a proven wire keeps its value for the rest of the tick
  a_r8_write_once: assert property (@(posedge clk) disable iff (rst)
    (w_q.known && !clear) |=> (w_q.known && (w_q.val == $past(w_q.val))));

  // R8: no consumption once the pending counter has reached zero
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (pend_q == '0) |-> !(new_ext || new_fb));
endmodule

// File: rtl/cn_ctrl.sv
module cn_ctrl #(
  parameter int TOTAL = 4,
  parameter int EW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          chg,
  input  logic [EW-1:0] ev_sum,
  output logic          run,
  output logic          clear,
  output logic          done_q,
  output logic          noncon_q
);
  localparam int MAX_STEPS = 2 * TOTAL + 1;
  localparam int SW        = $clog2(MAX_STEPS + 2);

  logic          run_q;
  logic [EW-1:0] ev_q;
  logic [SW-1:0] steps_q;
  logic [EW-1:0] ev_next;

  always_comb begin
    run     = run_q;
    clear   = start && !run_q;
    ev_next = ev_q + ev_sum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      noncon_q <= 1'b0;
      ev_q     <= '0;
      steps_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (clear) begin
        run_q    <= 1'b1;
        noncon_q <= 1'b0;
        ev_q     <= '0;
        steps_q  <= '0;
      end else if (run_q) begin
        ev_q    <= ev_next;
        steps_q <= steps_q + 1'b1;
        if (!chg) begin
          run_q    <= 1'b0;
          done_q   <= 1'b1;
          noncon_q <= (ev_next != EW'(TOTAL));
        end
      end
    end
  end

  // R6: done lasts one cycle
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R9: nonconstructive rises only together with done
  a_r9_flag_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(noncon_q) |-> done_q);

  // R10: the step count stays within the linear bound
  a_r10_step_bound: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (steps_q <= SW'(MAX_STEPS)));
endmodule

// File: rtl/cn_eval.sv
module cn_eval
  import cn_pkg::*;
#(
  parameter int FANIN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic src_a,
  input  logic src_b,
  output logic res_a,
  output logic res_b,
  output logic res_a_known,
  output logic res_b_known,
  output logic done,
  output logic nonconstructive
);
  localparam int TOTAL = N_GATES * FANIN;
  localparam int CW    = $clog2(FANIN + 1);
  localparam int EW    = $clog2(TOTAL + 1);

  logic                 run, clear, chg;
  logic                 src_known;
  logic [N_GATES-1:0]   src_q;
  fact_t                wire_f [N_GATES];
  logic [CW-1:0]        ev    [N_GATES];
  logic [N_GATES-1:0]   chg_v;
  logic [EW-1:0]        ev_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_known <= 1'b0;
      src_q     <= '0;
    end else if (clear) begin
      src_known <= 1'b1;
      src_q     <= {src_b, src_a};
    end
  end

  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    fact_t ext_f;
    assign ext_f = '{known: src_known, val: src_q[g]};
    cn_gate #(.FANIN(FANIN)) u_gate (
      .clk  (clk),
      .rst  (rst),
      .clear(clear),
      .step (run),
      .ext_i(ext_f),
      .fb_i (wire_f[N_GATES-1-g]),
      .out_o(wire_f[g]),
      .ev_o (ev[g]),
      .chg_o(chg_v[g])
    );
  end

  always_comb begin
    ev_sum = '0;
    for (int k = 0; k < N_GATES; k++) ev_sum = ev_sum + EW'(ev[k]);
    chg = |chg_v;
  end

  cn_ctrl #(.TOTAL(TOTAL), .EW(EW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .chg     (chg),
    .ev_sum  (ev_sum),
    .run     (run),
    .clear   (clear),
    .done_q  (done),
    .noncon_q(nonconstructive)
  );

  assign res_a       = wire_f[0].val;
  assign res_b       = wire_f[1].val;
  assign res_a_known = wire_f[0].known;
  assign res_b_known = wire_f[1].known;

  // R9: a constructive finish has every wire proven
  a_r9_constructive_full: assert property (@(posedge clk) disable iff (rst)
    (done && !nonconstructive) |-> (res_a_known && res_b_known));

  // R9: a nonconstructive finish leaves a wire unproven
  a_r9_noncon_partial: assert property (@(posedge clk) disable iff (rst)
    (done && nonconstructive) |-> !(res_a_known && res_b_known));

  // R5: the two wires can never both be proven 1
  a_r5_not_both_high: assert property (@(posedge clk) disable iff (rst)
    !(res_a_known && res_b_known && res_a && res_b));
endmodule

// File: tb/cn_eval_bench.sv
module cn_eval_bench;
  logic clk = 1'b0;
  logic rst, start, src_a, src_b;
  logic res_a, res_b, res_a_known, res_b_known, done, nonconstructive;
  int   total = 0;
  int   bad   = 0;
  bit   finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  cn_eval u_cn_eval (
    .clk(clk), .rst(rst), .start(start), .src_a(src_a), .src_b(src_b),
    .res_a(res_a), .res_b(res_b), .res_a_known(res_a_known),
    .res_b_known(res_b_known), .done(done), .nonconstructive(nonconstructive)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // run one tick; optional mid-tick start with other sources (R7)
  task automatic run_tick(string req, bit a, bit b, int exp_lat,
                          bit exp_ak, bit exp_a, bit exp_bk, bit exp_b,
                          bit exp_nc, bit poke);
    int lat = -1;
    @(negedge clk);
    src_a = a; src_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 12; c++) begin
      if (poke && c == 1) begin
        src_a = ~a; src_b = ~b; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      if (done && lat < 0) lat = c;
      if (lat >= 0) break;
    end
    check(req, "latency", lat, exp_lat);
    check(req, "a_known", res_a_known, exp_ak);
    check(req, "b_known", res_b_known, exp_bk);
    if (exp_ak) check(req, "res_a", res_a, exp_a);
    if (exp_bk) check(req, "res_b", res_b, exp_b);
    check(req, "nonconstructive", nonconstructive, exp_nc);
    // R6: pulse ends, results held
    src_a = ~a; src_b = ~b;
    @(negedge clk);
    check("R6", "done low after pulse", done, 0);
    check("R6", "a_known held", res_a_known, exp_ak);
    check("R6", "b_known held", res_b_known, exp_bk);
    check("R6", "nonconstructive held", nonconstructive, exp_nc);
    if (exp_ak) check("R6", "res_a held", res_a, exp_a);
  endtask

  task automatic test_reset();
    rst = 1'b1; start = 1'b0; src_a = 1'b0; src_b = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "done", done, 0);
    check("R1", "nonconstructive", nonconstructive, 0);
    check("R1", "a_known", res_a_known, 0);
    check("R1", "b_known", res_b_known, 0);
  endtask

  task automatic test_r2(); run_tick("R2", 0, 1, 4, 1, 0, 1, 1, 0, 0); endtask
  task automatic test_r3(); run_tick("R3", 1, 0, 4, 1, 1, 1, 0, 0, 0); endtask
  task automatic test_r4(); run_tick("R4", 0, 0, 3, 1, 0, 1, 0, 0, 0); endtask
  task automatic test_r5(); run_tick("R5", 1, 1, 2, 0, 0, 0, 0, 1, 0); endtask
  // R7: a start in mid-tick with swapped sources changes nothing
  task automatic test_r7(); run_tick("R7", 0, 1, 4, 1, 0, 1, 1, 0, 1); endtask
  // R9: a constructive tick right after a nonconstructive one clears the flag
  task automatic test_r9(); run_tick("R9", 1, 0, 4, 1, 1, 1, 0, 0, 0); endtask

  initial begin
    test_reset();
    test_r2();
    test_r3();
    test_r4();
    test_r5();
    test_r9();
    test_r5();
    test_r7();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule